// File: doc/BRIEF.md
# Dual Video Stream Plane Merger

This block takes two AXI4-Stream video streams and fuses them, pixel by pixel, into one wider stream. Each merged output pixel carries every color plane of input 0 in its low bits, with the planes of input 1 placed directly above them. A typical use is adding a separately generated alpha or depth plane to an RGB stream.

Both inputs carry packets. A sideband kind code marks each packet as one of four types: active video, image information, end of field, or auxiliary/user data. All non-video packets from input 0 pass through unchanged. On input 1, image-information and end-of-field packets are always consumed and discarded. Auxiliary/user packets from input 1 are forwarded only when `keep_aux_i` is high.

Video lines are paired one with one. The lines and frames of the two inputs do not have to match in size. The output line ends at the shorter of the two lines, and the output frame ends at the shorter of the two frames. The block drains the surplus pixels or lines on the other input and then starts merging again. The two inputs advance in lockstep through cross-coupled handshakes. A fixed register pipeline sets the latency, and that pipeline freezes under output backpressure.

Top module: `plane_merger`

## Requirements
- R1: For each pair of video beats accepted together, exactly one output beat is produced. Its `m_tdata_o` is {input-1 data, input-0 data}, its kind is 0 (video), `m_tuser_o` is copied from input 0, and `m_tlast_o` is the OR of the two input tlasts.
- R2: Every input-0 packet with kind 1 (image info), 2 (end of field) or 3 (aux/user) is forwarded in order, beat by beat, with the same kind and tlast. Its data sits in the low bits and the upper bits are zero. Input-0 non-video packets take priority over input-1 non-video packets.
- R3: Input-1 packets of kind 1 or kind 2 are consumed and never reach the output.
- R4: Input-1 packets of kind 3 are forwarded, with data in the low bits and zero above, when `keep_aux_i` is 1. They are consumed without output when `keep_aux_i` is 0.
- R5: When the two paired lines differ in length, the output line has the shorter length and carries tlast on its final beat. The remaining beats of the longer line are consumed, and merging starts again with the next line.
- R6: At the start of a line, if only one of the two head video beats has tuser (start of frame) set, the input whose head lacks tuser has its lines drained until that input also reaches a start of frame.
- R7: While merging, an input's tready is high only when the other input's tvalid and `m_tready_i` are both high.
- R8: While `m_tready_i` is low, no beat that would produce output is accepted, and a valid output beat holds all its fields stable.
- R9: While an input is being drained, its tready is high regardless of the other input and of `m_tready_i`, and no output is produced.
- R10: With `m_tready_i` held high, the output handshake of a beat comes exactly LATENCY cycles (default 15) after its input handshake. Cycles of output backpressure add to this one for one.
- R11: When both inputs assert tlast on the same beat, no drain follows, and the next pair of lines merges with no beat lost.
- R12: After reset, `m_tvalid_o`, `s0_tready_o` and `s1_tready_o` are all low while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keep_aux_i | input | 1 | Forward input-1 aux/user packets when high |
| s0_tdata_i | input | PLANE_W*PLANES0 | Input 0 pixel or packet data |
| s0_tkind_i | input | 2 | Input 0 packet kind: 0 video, 1 info, 2 end of field, 3 aux |
| s0_tuser_i | input | 1 | Input 0 start of frame, set on the first video beat of a frame |
| s0_tlast_i | input | 1 | Input 0 end of packet or line |
| s0_tvalid_i | input | 1 | Input 0 valid |
| s0_tready_o | output | 1 | Input 0 ready |
| s1_tdata_i | input | PLANE_W*PLANES1 | Input 1 pixel or packet data |
| s1_tkind_i | input | 2 | Input 1 packet kind, same coding as input 0 |
| s1_tuser_i | input | 1 | Input 1 start of frame |
| s1_tlast_i | input | 1 | Input 1 end of packet or line |
| s1_tvalid_i | input | 1 | Input 1 valid |
| s1_tready_o | output | 1 | Input 1 ready |
| m_tdata_o | output | PLANE_W*(PLANES0+PLANES1) | Output data |
| m_tkind_o | output | 2 | Output packet kind |
| m_tuser_o | output | 1 | Output start of frame |
| m_tlast_o | output | 1 | Output end of packet or line |
| m_tvalid_o | output | 1 | Output valid |
| m_tready_i | input | 1 | Output ready |

## Verification
The bound checker checks the handshake rules on every cycle. These are the lockstep readiness while merging, the blocking of productive inputs under backpressure, the open tready of a drained input, the stable output during a stall, and start-of-frame appearing only on video beats. Several behaviours appear only in the bench's frame scenarios against its reference queues, with random stalls on all three ports. Those are the exact output line lengths and frame heights under mismatch, the content and order of merged pixels, the dropping or forwarding of input-1 metadata, and the exact pipeline latency.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  typedef enum logic [1:0] {
    KIND_VIDEO = 2'd0,
    KIND_INFO  = 2'd1,
    KIND_EOF   = 2'd2,
    KIND_AUX   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_FWD0   = 3'd1,
    MODE_FWD1   = 3'd2,
    MODE_DROP1  = 3'd3,
    MODE_MERGE  = 3'd4,
    MODE_DRAIN0 = 3'd5,
    MODE_DRAIN1 = 3'd6
  } mode_e;
endpackage

// File: rtl/pm_sched.sv
`timescale 1ns/1ps
module pm_sched
  import pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       keep_aux_i,
  input  logic       s0_valid_i,
  input  logic [1:0] s0_kind_i,
  input  logic       s0_sof_i,
  input  logic       s0_last_i,
  input  logic       s1_valid_i,
  input  logic [1:0] s1_kind_i,
  input  logic       s1_sof_i,
  input  logic       s1_last_i,
  input  logic       out_ready_i,
  output logic       s0_ready_o,
  output logic       s1_ready_o,
  output logic       push_o,
  output mode_e      mode_o
);
  mode_e state_q, pick, mode, nxt;
  logic  fire0, fire1;

  // choose the next packet at a boundary: input-0 meta, input-1 meta, then video
  always_comb begin
    pick = MODE_IDLE;
    if (s0_valid_i && s0_kind_i != KIND_VIDEO)
      pick = MODE_FWD0;
    else if (s1_valid_i && s1_kind_i != KIND_VIDEO)
      pick = (keep_aux_i && s1_kind_i == KIND_AUX) ? MODE_FWD1 : MODE_DROP1;
    else if (s0_valid_i && s1_valid_i) begin
      if (s0_sof_i == s1_sof_i) pick = MODE_MERGE;
      else if (s1_sof_i)        pick = MODE_DRAIN0;
      else                      pick = MODE_DRAIN1;
    end
  end

  assign mode = (state_q == MODE_IDLE) ? pick : state_q;

  always_comb begin
    s0_ready_o = 1'b0;
    s1_ready_o = 1'b0;
    push_o     = 1'b0;
    case (mode)
      MODE_FWD0: begin
        s0_ready_o = out_ready_i;
        push_o     = s0_valid_i && out_ready_i;
      end
      MODE_FWD1: begin
        s1_ready_o = out_ready_i;
        push_o     = s1_valid_i && out_ready_i;
      end
      MODE_DROP1:  s1_ready_o = 1'b1;
      MODE_MERGE: begin
        s0_ready_o = s1_valid_i && out_ready_i;
        s1_ready_o = s0_valid_i && out_ready_i;
        push_o     = s0_valid_i && s1_valid_i && out_ready_i;
      end
      MODE_DRAIN0: s0_ready_o = 1'b1;
      MODE_DRAIN1: s1_ready_o = 1'b1;
      default: ;
    endcase
  end

  assign fire0 = s0_valid_i && s0_ready_o;
  assign fire1 = s1_valid_i && s1_ready_o;

  always_comb begin
    nxt = mode;
    case (mode)
      MODE_FWD0, MODE_DRAIN0:
        if (fire0 && s0_last_i) nxt = MODE_IDLE;
      MODE_FWD1, MODE_DROP1, MODE_DRAIN1:
        if (fire1 && s1_last_i) nxt = MODE_IDLE;
      MODE_MERGE:
        if (push_o) begin
          if (s0_last_i && s1_last_i) nxt = MODE_IDLE;
          else if (s0_last_i)         nxt = MODE_DRAIN1;
          else if (s1_last_i)         nxt = MODE_DRAIN0;
        end
      default: nxt = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MODE_IDLE;
    else         state_q <= nxt;
  end

  assign mode_o = mode;
endmodule

// File: rtl/pm_pack.sv
`timescale 1ns/1ps
module pm_pack
  import pm_pkg::*;
#(
  parameter int W0 = 24,
  parameter int W1 = 8,
  localparam int WO = W0 + W1
) (
  input  mode_e          mode_i,
  input  logic [W0-1:0]  s0_data_i,
  input  logic [1:0]     s0_kind_i,
  input  logic           s0_sof_i,
  input  logic           s0_last_i,
  input  logic [W1-1:0]  s1_data_i,
  input  logic [1:0]     s1_kind_i,
  input  logic           s1_last_i,
  output logic [WO-1:0]  data_o,
  output logic [1:0]     kind_o,
  output logic           sof_o,
  output logic           last_o
);
  always_comb begin
    case (mode_i)
      MODE_MERGE: begin
        data_o = {s1_data_i, s0_data_i};
        kind_o = KIND_VIDEO;
        sof_o  = s0_sof_i;
        last_o = s0_last_i | s1_last_i;
      end
      MODE_FWD1: begin
        data_o = {{(WO-W1){1'b0}}, s1_data_i};
        kind_o = s1_kind_i;
        sof_o  = 1'b0;
        last_o = s1_last_i;
      end
      default: begin
        data_o = {{(WO-W0){1'b0}}, s0_data_i};
        kind_o = s0_kind_i;
        sof_o  = 1'b0;
        last_o = s0_last_i;
      end
    endcase
  end
endmodule

// File: rtl/pm_delay_pipe.sv
`timescale 1ns/1ps
module pm_delay_pipe #(
  parameter int W     = 36,
  parameter int DEPTH = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic         v_in, v_q;
    logic [W-1:0] d_in, d_q;
    if (g == 0) begin : g_head
      assign v_in = valid_i;
      assign d_in = data_i;
    end else begin : g_body
      assign v_in = g_stage[g-1].v_q;
      assign d_in = g_stage[g-1].d_q;
    end
    // whole pipe freezes on output stall, so backpressure adds latency 1:1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (en_i) begin
        v_q <= v_in;
        d_q <= d_in;
      end
    end
  end

  assign valid_o = g_stage[DEPTH-1].v_q;
  assign data_o  = g_stage[DEPTH-1].d_q;
endmodule

// File: rtl/plane_merger.sv
`timescale 1ns/1ps
module plane_merger
  import pm_pkg::*;
#(
  parameter int PLANE_W = 8,
  parameter int PLANES0 = 3,
  parameter int PLANES1 = 1,
  parameter int LATENCY = 15,
  localparam int W0 = PLANE_W * PLANES0,
  localparam int W1 = PLANE_W * PLANES1,
  localparam int WO = W0 + W1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          keep_aux_i,
  input  logic [W0-1:0] s0_tdata_i,
  input  logic [1:0]    s0_tkind_i,
  input  logic          s0_tuser_i,
  input  logic          s0_tlast_i,
  input  logic          s0_tvalid_i,
  output logic          s0_tready_o,
  input  logic [W1-1:0] s1_tdata_i,
  input  logic [1:0]    s1_tkind_i,
  input  logic          s1_tuser_i,
  input  logic          s1_tlast_i,
  input  logic          s1_tvalid_i,
  output logic          s1_tready_o,
  output logic [WO-1:0] m_tdata_o,
  output logic [1:0]    m_tkind_o,
  output logic          m_tuser_o,
  output logic          m_tlast_o,
  output logic          m_tvalid_o,
  input  logic          m_tready_i
);
  typedef struct packed {
    logic          sof;
    logic          last;
    logic [1:0]    kind;
    logic [WO-1:0] data;
  } beat_t;
  localparam int BW = $bits(beat_t);

  mode_e mode;
  logic  push;
  beat_t beat_in, beat_out;

  pm_sched u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .keep_aux_i  (keep_aux_i),
    .s0_valid_i  (s0_tvalid_i),
    .s0_kind_i   (s0_tkind_i),
    .s0_sof_i    (s0_tuser_i),
    .s0_last_i   (s0_tlast_i),
    .s1_valid_i  (s1_tvalid_i),
    .s1_kind_i   (s1_tkind_i),
    .s1_sof_i    (s1_tuser_i),
    .s1_last_i   (s1_tlast_i),
    .out_ready_i (m_tready_i),
    .s0_ready_o  (s0_tready_o),
    .s1_ready_o  (s1_tready_o),
    .push_o      (push),
    .mode_o      (mode)
  );

  pm_pack #(.W0(W0), .W1(W1)) u_pack (
    .mode_i    (mode),
    .s0_data_i (s0_tdata_i),
    .s0_kind_i (s0_tkind_i),
    .s0_sof_i  (s0_tuser_i),
    .s0_last_i (s0_tlast_i),
    .s1_data_i (s1_tdata_i),
    .s1_kind_i (s1_tkind_i),
    .s1_last_i (s1_tlast_i),
    .data_o    (beat_in.data),
    .kind_o    (beat_in.kind),
    .sof_o     (beat_in.sof),
    .last_o    (beat_in.last)
  );

  pm_delay_pipe #(.W(BW), .DEPTH(LATENCY)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (m_tready_i),
    .valid_i (push),
    .data_i  (beat_in),
    .valid_o (m_tvalid_o),
    .data_o  (beat_out)
  );

  assign m_tdata_o = beat_out.data;
  assign m_tkind_o = beat_out.kind;
  assign m_tuser_o = beat_out.sof;
  assign m_tlast_o = beat_out.last;
endmodule

// File: rtl/plane_merger_chk.sv
`timescale 1ns/1ps
module plane_merger_chk
  import pm_pkg::*;
#(
  parameter int WO = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s0_tvalid_i,
  input logic          s0_tready_o,
  input logic          s1_tvalid_i,
  input logic          s1_tready_o,
  input logic [WO-1:0] m_tdata_o,
  input logic [1:0]    m_tkind_o,
  input logic          m_tuser_o,
  input logic          m_tlast_o,
  input logic          m_tvalid_o,
  input logic          m_tready_i,
  input mode_e         mode_i
);
  assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) && $stable(m_tkind_o)
      && $stable(m_tuser_o) && $stable(m_tlast_o));

  assert_stall_in0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tready_i && s0_tready_o |-> mode_i == MODE_DRAIN0);

  assert_stall_in1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tready_i && s1_tready_o |-> (mode_i == MODE_DRAIN1 || mode_i == MODE_DROP1));

  assert_lockstep_in0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_MERGE && s0_tready_o |-> s1_tvalid_i && m_tready_i);

  assert_lockstep_in1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_MERGE && s1_tready_o |-> s0_tvalid_i && m_tready_i);

  assert_drain0_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DRAIN0 |-> s0_tready_o && !s1_tready_o);

  assert_drain1_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_DRAIN1 |-> s1_tready_o && !s0_tready_o);

  assert_sof_on_video_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tuser_o |-> m_tkind_o == KIND_VIDEO);
endmodule

bind plane_merger plane_merger_chk #(.WO(WO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .s0_tvalid_i (s0_tvalid_i),
  .s0_tready_o (s0_tready_o),
  .s1_tvalid_i (s1_tvalid_i),
  .s1_tready_o (s1_tready_o),
  .m_tdata_o   (m_tdata_o),
  .m_tkind_o   (m_tkind_o),
  .m_tuser_o   (m_tuser_o),
  .m_tlast_o   (m_tlast_o),
  .m_tvalid_o  (m_tvalid_o),
  .m_tready_i  (m_tready_i),
  .mode_i      (mode)
);

// File: tb/plane_merger_tb.sv
`timescale 1ns/1ps
module plane_merger_tb;
  localparam int LAT = 15;

  typedef struct {
    logic [31:0] d;
    logic [1:0]  k;
    logic        sof;
    logic        last;
  } bt_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        keep = 1'b1;
  logic [23:0] s0_tdata_i = '0;
  logic [1:0]  s0_tkind_i = '0;
  logic        s0_tuser_i = 1'b0, s0_tlast_i = 1'b0, s0_tvalid_i = 1'b0;
  logic        s0_tready_o;
  logic [7:0]  s1_tdata_i = '0;
  logic [1:0]  s1_tkind_i = '0;
  logic        s1_tuser_i = 1'b0, s1_tlast_i = 1'b0, s1_tvalid_i = 1'b0;
  logic        s1_tready_o;
  logic [31:0] m_tdata_o;
  logic [1:0]  m_tkind_o;
  logic        m_tuser_o, m_tlast_o, m_tvalid_o;
  logic        m_tready_i = 1'b0;

  int tests = 0, fails = 0, seq = 0, bad_in1 = 0;
  bit done = 0;
  bt_t q_in0[$], q_in1[$], q_main[$], q_aux[$];

  always #4 clk = ~clk;

  plane_merger #(.LATENCY(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .keep_aux_i(keep),
    .s0_tdata_i(s0_tdata_i), .s0_tkind_i(s0_tkind_i), .s0_tuser_i(s0_tuser_i),
    .s0_tlast_i(s0_tlast_i), .s0_tvalid_i(s0_tvalid_i), .s0_tready_o(s0_tready_o),
    .s1_tdata_i(s1_tdata_i), .s1_tkind_i(s1_tkind_i), .s1_tuser_i(s1_tuser_i),
    .s1_tlast_i(s1_tlast_i), .s1_tvalid_i(s1_tvalid_i), .s1_tready_o(s1_tready_o),
    .m_tdata_o(m_tdata_o), .m_tkind_o(m_tkind_o), .m_tuser_o(m_tuser_o),
    .m_tlast_o(m_tlast_o), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // input-0 metadata: bit 7 clear marks it as coming from input 0
  task automatic add_meta0(logic [1:0] k, int len);
    for (int j = 0; j < len; j++) begin
      bt_t b;
      seq++;
      b.d = {8'h0, 8'(seq), 8'(seq * 3), 1'b0, 7'(seq)};
      b.k = k; b.sof = 1'b0; b.last = (j == len - 1);
      q_in0.push_back(b);
      q_main.push_back(b);
    end
  endtask

  // input-1 metadata: bit 7 set marks it
  task automatic add_meta1(logic [1:0] k, int len);
    for (int j = 0; j < len; j++) begin
      bt_t b;
      seq++;
      b.d = {24'h0, 1'b1, 7'(seq)};
      b.k = k; b.sof = 1'b0; b.last = (j == len - 1);
      q_in1.push_back(b);
      if (keep && k == 2'd3) q_aux.push_back(b);
    end
  endtask

  task automatic add_frame(int h0, int l0, int h1, int l1);
    int hm = (h0 < h1) ? h0 : h1;
    int lm = (l0 < l1) ? l0 : l1;
    int hx = (h0 > h1) ? h0 : h1;
    int lx = (l0 > l1) ? l0 : l1;
    add_meta0(2'd1, 2); add_meta0(2'd3, 1);
    add_meta1(2'd1, 1); add_meta1(2'd3, 2);
    for (int i = 0; i < hx; i++) begin
      for (int j = 0; j < lx; j++) begin
        bt_t b0, b1, e;
        b0.d = {8'h0, 24'($urandom)}; b0.k = 2'd0; b0.sof = (i == 0 && j == 0); b0.last = (j == l0 - 1);
        b1.d = {24'h0, 8'($urandom)}; b1.k = 2'd0; b1.sof = (i == 0 && j == 0); b1.last = (j == l1 - 1);
        if (i < h0 && j < l0) q_in0.push_back(b0);
        if (i < h1 && j < l1) q_in1.push_back(b1);
        if (i < hm && j < lm) begin
          e.d = {b1.d[7:0], b0.d[23:0]}; e.k = 2'd0; e.sof = b0.sof; e.last = (j == lm - 1);
          q_main.push_back(e);
        end
      end
    end
    add_meta0(2'd2, 1); add_meta1(2'd2, 1);
  endtask

  task automatic drive0();
    bit have = 0; bt_t cur;
    forever begin
      @(negedge clk);
      if (!have && q_in0.size() > 0 && $urandom_range(0, 3) != 0) begin
        cur = q_in0.pop_front(); have = 1;
      end
      s0_tvalid_i = have;
      s0_tdata_i = cur.d[23:0]; s0_tkind_i = cur.k; s0_tuser_i = cur.sof; s0_tlast_i = cur.last;
      #3;
      if (have && s0_tready_o) have = 0;
    end
  endtask

  task automatic drive1();
    bit have = 0; bt_t cur;
    forever begin
      @(negedge clk);
      if (!have && q_in1.size() > 0 && $urandom_range(0, 3) != 0) begin
        cur = q_in1.pop_front(); have = 1;
      end
      s1_tvalid_i = have;
      s1_tdata_i = cur.d[7:0]; s1_tkind_i = cur.k; s1_tuser_i = cur.sof; s1_tlast_i = cur.last;
      #3;
      if (have && s1_tready_o) have = 0;
    end
  endtask

  task automatic monitor();
    bit stalled = 0;
    logic [35:0] prev = '0, now;
    forever begin
      @(negedge clk);
      m_tready_i = ($urandom_range(0, 3) != 0);
      #3;
      now = {m_tuser_o, m_tlast_o, m_tkind_o, m_tdata_o};
      if (stalled) chk(m_tvalid_o && now == prev, "R8 output held under stall", now, prev);
      stalled = m_tvalid_o && !m_tready_i;
      prev = now;
      if (m_tvalid_o && m_tready_i) begin
        bt_t e;
        bit from1 = (m_tkind_o != 2'd0) && m_tdata_o[7];
        if (from1 && m_tkind_o != 2'd3) bad_in1++;
        if (from1) begin
          if (q_aux.size() == 0) begin
            chk(0, "R3 R4 unexpected input-1 metadata", m_tdata_o, 0);
            continue;
          end
          e = q_aux.pop_front();
          chk({m_tdata_o, m_tkind_o, m_tlast_o, m_tuser_o} == {e.d, e.k, e.last, e.sof},
              "R4 input-1 aux beat", {m_tdata_o, m_tkind_o, m_tlast_o, m_tuser_o},
              {e.d, e.k, e.last, e.sof});
        end else begin
          if (q_main.size() == 0) begin
            chk(0, "R1 R2 unexpected output beat", m_tdata_o, 0);
            continue;
          end
          e = q_main.pop_front();
          chk({m_tdata_o, m_tkind_o, m_tlast_o, m_tuser_o} == {e.d, e.k, e.last, e.sof},
              (e.k == 2'd0) ? "R1 R5 R6 R11 merged video beat" : "R2 input-0 metadata beat",
              {m_tdata_o, m_tkind_o, m_tlast_o, m_tuser_o}, {e.d, e.k, e.last, e.sof});
        end
      end
    end
  endtask

  task automatic settle();
    int guard = 0;
    while ((q_in0.size() + q_in1.size() + q_main.size() + q_aux.size()) != 0 && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (LAT + 40) @(negedge clk);
    chk(q_main.size() == 0, "R5 R6 all merged lines and input-0 packets delivered", q_main.size(), 0);
    chk(q_aux.size() == 0, "R4 all kept input-1 aux beats delivered", q_aux.size(), 0);
    chk(bad_in1 == 0, "R3 no input-1 info or end-of-field beat on output", bad_in1, 0);
  endtask

  initial begin : wd
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R10 run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #3;
    chk(!m_tvalid_o && !s0_tready_o && !s1_tready_o, "R12 idle after reset",
        {m_tvalid_o, s0_tready_o, s1_tready_o}, 0);

    // directed: lockstep, stall, drain, latency
    @(negedge clk);
    s0_tvalid_i = 1; s0_tkind_i = 0; s0_tuser_i = 1; s0_tlast_i = 0; s0_tdata_i = 24'hA1B2C3;
    m_tready_i = 1; #3;
    chk(!s0_tready_o, "R7 input 0 waits for input 1", s0_tready_o, 0);
    @(negedge clk);
    s1_tvalid_i = 1; s1_tkind_i = 0; s1_tuser_i = 1; s1_tlast_i = 1; s1_tdata_i = 8'h5E;
    m_tready_i = 0; #3;
    chk(!s0_tready_o && !s1_tready_o, "R8 both inputs blocked by output stall",
        {s0_tready_o, s1_tready_o}, 0);
    @(negedge clk);
    m_tready_i = 1; #3;
    chk(s0_tready_o && s1_tready_o, "R7 both ready when both valid", {s0_tready_o, s1_tready_o}, 2'b11);
    n = 0;
    @(negedge clk);
    s1_tvalid_i = 0; s0_tuser_i = 0; s0_tdata_i = 24'h111111; #3; n++;
    chk(s0_tready_o, "R9 drained input ready without input 1", s0_tready_o, 1);
    @(negedge clk);
    s0_tlast_i = 1; s0_tdata_i = 24'h222222; #3; n++;
    chk(s0_tready_o, "R9 drain continues to line end", s0_tready_o, 1);
    @(negedge clk);
    s0_tvalid_i = 0; s0_tlast_i = 0; #3; n++;
    while (!m_tvalid_o && n < LAT + 10) begin
      @(negedge clk); #3; n++;
    end
    chk(n == LAT, "R10 latency in cycles", n, LAT);
    chk(m_tvalid_o && m_tdata_o == 32'h5EA1B2C3 && m_tlast_o && m_tuser_o && m_tkind_o == 0,
        "R1 R5 truncated one-beat merged line", {m_tvalid_o, m_tdata_o, m_tlast_o, m_tuser_o},
        {1'b1, 32'h5EA1B2C3, 1'b1, 1'b1});
    @(negedge clk); #3;
    chk(!m_tvalid_o, "R9 drained beats produce no output", m_tvalid_o, 0);

    fork
      drive0();
      drive1();
      monitor();
    join_none

    // phase 1: input-1 aux kept
    keep = 1;
    add_frame(2, 4, 2, 4);
    add_frame(3, 5, 2, 3);
    add_frame(2, 3, 3, 6);
    add_frame(1, 2, 1, 7);
    add_frame(2, 3, 2, 3);
    settle();

    // phase 2: input-1 aux dropped
    keep = 0;
    add_frame(2, 6, 3, 2);
    add_frame(3, 1, 1, 1);
    add_frame(2, 4, 2, 4);
    settle();

    done = 1;
    summary();
    $finish;
  end
endmodule